// File: doc/BRIEF.md
# Streaming Arithmetic Expression Evaluator

This block takes a stream of 16-bit tokens and evaluates the integer expression they spell. The expression may use addition, multiplication and parentheses. One token is taken per accepted cycle over a valid/ready handshake. The block runs a shift-reduce parse on a small stack of tagged items. Each reduction also does its arithmetic, so the final expression item carries the answer.

The parser keeps no separate state register. Each cycle it recognises its state by comparing the tags of the top one to three stack entries against twelve fixed patterns. Where two patterns match at once, the longer one wins. The lookahead token then selects one of four actions:

- shift the token onto the stack;
- reduce the top entries;
- accept the parse;
- raise an error.

A source of tokens drives the stream until the done flag or the error flag rises. Both flags are sticky. Only a reset starts a new expression.

Top module: `srExprEval`

## Requirements
- R1: After reset the stack holds only a bottom marker, item 0x5A00. The done flag, the error flag and the result are all 0, and an integer token offered in this state is accepted at once.
- R2: Bits 15:8 of a token are its type tag and bits 7:0 are its value. Only the tag selects the parse action. The tags are: integer 0xE1, open paren 0xCA, close paren 0xCB, add 0xAA, multiply 0xAB, end 0x55. An integer whose value byte is 0xAB evaluates as that number.
- R3: Some states expect an operand: the start, after an open paren, after add and after multiply. There only an integer or an open paren is legal. After an open paren followed by an expression, only add or close paren is legal. After an operand item, only add, multiply, close paren or end is legal. An illegal token sets a sticky error flag, is never accepted, and the parser stays stopped until reset.
- R4: Ready is low in every reduce cycle. A token offered then is held and not consumed. It is taken on the first cycle in which the parser shifts or accepts it.
- R5: Multiplication binds tighter than addition: 2+3*4 gives 14, and 2*3+4 gives 10.
- R6: The reductions work as follows. Expression-add-term becomes an expression holding the sum. Term-multiply-factor becomes a term holding the product. Open-expression-close becomes a factor holding the inner value. Integer becomes factor, factor becomes term, and term becomes expression, each keeping its value. Sums and products keep only their low 8 bits.
- R7: An expression directly above the bottom marker, with the end token as lookahead, consumes that token. From the next cycle the done flag is high and the result holds the value. Both then stay fixed and ready stays low.
- R8: The stack holds 16 entries, counting the bottom marker. A shift onto a full stack sets the error flag instead.
- R9: Nested parentheses evaluate correctly: ( ( 2 ) + 3 ) + 1 end gives 6.
- R10: When a three-entry pattern and a one-entry pattern both match, the three-entry pattern decides the action. So 1+2 end reduces to 3 without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| tokValid | input | 1 | A token is offered on tokIn |
| tokIn | input | 16 | Token: tag in bits 15:8, value in bits 7:0 |
| tokReady | output | 1 | The offered token is consumed at this edge |
| parseDone | output | 1 | Sticky: the expression has been evaluated |
| parseError | output | 1 | Sticky: illegal token or stack overflow |
| resultVal | output | 8 | Value of the completed expression |

## Verification
The assertions check on every cycle these properties:

- both flags are sticky and never both set;
- the result holds still except at acceptance;
- at most one stack action happens per cycle;
- the bottom marker is never overwritten;
- no push lands on a full stack and no three-entry reduction reaches below the marker;
- after the priority rule, at most one stack pattern remains.

Only the bench's scenarios can show the rest: that values come out right, that multiplication takes precedence, that exactly the right tokens are rejected, and how many cycles a token waits behind a chain of reductions. It shows these by running whole expressions against a behavioural model.

// File: rtl/srExprPkg.sv
package srExprPkg;

  localparam int TAG_W = 8;

  typedef logic [TAG_W-1:0] tag_t;

  localparam tag_t TAG_NONE  = 8'h00;
  localparam tag_t TAG_BOT   = 8'h5A;
  localparam tag_t TAG_END   = 8'h55;
  localparam tag_t TAG_EXPR  = 8'hEE;
  localparam tag_t TAG_TERM  = 8'hE7;
  localparam tag_t TAG_FACT  = 8'hEF;
  localparam tag_t TAG_INT   = 8'hE1;
  localparam tag_t TAG_OPEN  = 8'hCA;
  localparam tag_t TAG_CLOSE = 8'hCB;
  localparam tag_t TAG_ADD   = 8'hAA;
  localparam tag_t TAG_MUL   = 8'hAB;

  localparam int N_STATES = 12;

  // Stack-top states; the index order matches the pattern tables.
  typedef enum logic [3:0] {
    ST_START, ST_BOT_EXPR, ST_TERM, ST_FACT, ST_OPEN, ST_INT,
    ST_EXPR_ADD, ST_TERM_MUL, ST_OPEN_EXPR, ST_SUM, ST_PROD, ST_PAREN,
    ST_NONE
  } pstate_e;

  typedef enum logic [2:0] {
    ACT_IDLE, ACT_SHIFT, ACT_REDUCE, ACT_ACCEPT, ACT_BAD
  } act_e;

  typedef enum logic [2:0] {
    RK_NONE, RK_SUM, RK_PROD, RK_PAREN, RK_INT2F, RK_F2T, RK_T2E
  } redKind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     push;
    logic     reduce;
    logic     accept;
    redKind_e kind;
  } strobe_t;

endpackage

// File: rtl/srExprStack.sv
module srExprStack
  import srExprPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ITEM_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [ITEM_W-1:0]         tokIn,
  output logic [ITEM_W-1:0]         top0,
  output logic [ITEM_W-1:0]         top1,
  output logic [ITEM_W-1:0]         top2,
  output logic                      full,
  output logic [ITEM_W-TAG_W-1:0]   resultVal
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int VAL_W = ITEM_W - TAG_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [ITEM_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  topPtr;
  logic [IDX_W-1:0]  destPtr;
  logic [ITEM_W-1:0] newItem;
  logic [VAL_W-1:0]  v0, v1, v2;
  logic [VAL_W-1:0]  sumV, prodV;
  logic              longRed;
  logic [VAL_W-1:0]  resultReg;

  // Views of the top three entries; a missing entry reads as tag 0.
  always_comb begin
    top0 = mem[topPtr];
    top1 = (topPtr >= IDX_W'(1)) ? mem[topPtr - IDX_W'(1)] : '0;
    top2 = (topPtr >= IDX_W'(2)) ? mem[topPtr - IDX_W'(2)] : '0;
  end

  assign full = (topPtr == LAST_IDX);

  assign v0 = top0[VAL_W-1:0];
  assign v1 = top1[VAL_W-1:0];
  assign v2 = top2[VAL_W-1:0];

  // Arithmetic truncates to the value byte.
  assign sumV  = v2 + v0;
  assign prodV = v2 * v0;

  always_comb begin
    longRed = 1'b0;
    newItem = top0;
    case (strb.kind)
      RK_SUM:   begin newItem = {TAG_EXPR, sumV};  longRed = 1'b1; end
      RK_PROD:  begin newItem = {TAG_TERM, prodV}; longRed = 1'b1; end
      RK_PAREN: begin newItem = {TAG_FACT, v1};    longRed = 1'b1; end
      RK_INT2F: newItem = {TAG_FACT, v0};
      RK_F2T:   newItem = {TAG_TERM, v0};
      RK_T2E:   newItem = {TAG_EXPR, v0};
      default:  newItem = top0;
    endcase
  end

  assign destPtr = longRed ? (topPtr - IDX_W'(2)) : topPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 1; i < DEPTH; i++) mem[i] <= '0;
      mem[0]    <= {TAG_BOT, {VAL_W{1'b0}}};
      topPtr    <= '0;
      resultReg <= '0;
    end else begin
      if (strb.push) begin
        mem[topPtr + IDX_W'(1)] <= tokIn;
        topPtr                  <= topPtr + IDX_W'(1);
      end else if (strb.reduce) begin
        mem[destPtr] <= newItem;
        topPtr       <= destPtr;
      end
      if (strb.accept) resultReg <= v0;
    end
  end

  assign resultVal = resultReg;

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.push, strb.reduce, strb.accept})); // R4
  AST_BOTTOM_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    mem[0] == {TAG_BOT, {VAL_W{1'b0}}}); // R1
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> topPtr != LAST_IDX); // R8
  AST_REDUCE_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (strb.reduce && longRed) |-> topPtr >= IDX_W'(3)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accept |=> $stable(resultVal)); // R7

endmodule

// File: rtl/srExprCtrl.sv
module srExprCtrl
  import srExprPkg::*;
#(
  parameter int ITEM_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [ITEM_W-1:0] tokIn,
  input  logic [ITEM_W-1:0] top0,
  input  logic [ITEM_W-1:0] top1,
  input  logic [ITEM_W-1:0] top2,
  input  logic              full,
  output logic              tokReady,
  output strobe_t           strb,
  output logic              parseDone,
  output logic              parseError
);

  // Pattern tables, bottom of the pattern first: T2 under T1 under T0.
  localparam int   PAT_LEN [N_STATES] = '{1, 2, 1, 1, 1, 1, 2, 2, 2, 3, 3, 3};
  localparam tag_t PAT_T0  [N_STATES] = '{TAG_BOT, TAG_EXPR, TAG_TERM, TAG_FACT,
                                          TAG_OPEN, TAG_INT, TAG_ADD, TAG_MUL,
                                          TAG_EXPR, TAG_TERM, TAG_FACT, TAG_CLOSE};
  localparam tag_t PAT_T1  [N_STATES] = '{TAG_NONE, TAG_BOT, TAG_NONE, TAG_NONE,
                                          TAG_NONE, TAG_NONE, TAG_EXPR, TAG_TERM,
                                          TAG_OPEN, TAG_ADD, TAG_MUL, TAG_EXPR};
  localparam tag_t PAT_T2  [N_STATES] = '{TAG_NONE, TAG_NONE, TAG_NONE, TAG_NONE,
                                          TAG_NONE, TAG_NONE, TAG_NONE, TAG_NONE,
                                          TAG_NONE, TAG_EXPR, TAG_TERM, TAG_OPEN};

  // Overlap resolution: winner index suppresses loser index.
  localparam int N_PRI = 3;
  localparam int PRI_WIN  [N_PRI] = '{1, 9, 10};
  localparam int PRI_LOSE [N_PRI] = '{8, 2, 3};

  tag_t t0, t1, t2, look;
  logic [N_STATES-1:0] rawHit, hit;
  pstate_e  state;
  act_e     act;
  redKind_e kind;
  logic     isOperand, isFollow;
  logic     run, errSet, doneSet;
  logic     doneReg, errReg;

  assign t0   = top0[ITEM_W-1 -: TAG_W];
  assign t1   = top1[ITEM_W-1 -: TAG_W];
  assign t2   = top2[ITEM_W-1 -: TAG_W];
  assign look = tokIn[ITEM_W-1 -: TAG_W];

  for (genvar s = 0; s < N_STATES; s++) begin : g_pat
    assign rawHit[s] = (t0 == PAT_T0[s])
                    && (PAT_LEN[s] < 2 || t1 == PAT_T1[s])
                    && (PAT_LEN[s] < 3 || t2 == PAT_T2[s]);
  end

  always_comb begin
    hit = rawHit;
    for (int p = 0; p < N_PRI; p++)
      if (rawHit[PRI_WIN[p]]) hit[PRI_LOSE[p]] = 1'b0;
  end

  always_comb begin
    state = ST_NONE;
    for (int s = N_STATES - 1; s >= 0; s--)
      if (hit[s]) state = pstate_e'(s[3:0]);
  end

  assign isOperand = (look == TAG_INT) || (look == TAG_OPEN);
  assign isFollow  = (look == TAG_ADD) || (look == TAG_MUL)
                  || (look == TAG_CLOSE) || (look == TAG_END);

  always_comb begin
    act  = ACT_BAD;
    kind = RK_NONE;
    case (state)
      ST_START, ST_OPEN, ST_EXPR_ADD, ST_TERM_MUL:
        if (isOperand) act = ACT_SHIFT;
      ST_BOT_EXPR:
        if (look == TAG_ADD)      act = ACT_SHIFT;
        else if (look == TAG_END) act = ACT_ACCEPT;
      ST_OPEN_EXPR:
        if (look == TAG_ADD || look == TAG_CLOSE) act = ACT_SHIFT;
      ST_TERM, ST_SUM:
        if (look == TAG_MUL) act = ACT_SHIFT;
        else if (isFollow) begin
          act  = ACT_REDUCE;
          kind = (state == ST_SUM) ? RK_SUM : RK_T2E;
        end
      ST_FACT:  if (isFollow) begin act = ACT_REDUCE; kind = RK_F2T;   end
      ST_INT:   if (isFollow) begin act = ACT_REDUCE; kind = RK_INT2F; end
      ST_PROD:  if (isFollow) begin act = ACT_REDUCE; kind = RK_PROD;  end
      ST_PAREN: if (isFollow) begin act = ACT_REDUCE; kind = RK_PAREN; end
      default:  act = ACT_BAD;
    endcase
    if (!tokValid) act = ACT_IDLE;
  end

  assign run      = !errReg && !doneReg;
  assign tokReady = run && ((act == ACT_SHIFT && !full) || act == ACT_ACCEPT);
  assign errSet   = run && (act == ACT_BAD || (act == ACT_SHIFT && full));
  assign doneSet  = run && (act == ACT_ACCEPT);

  always_comb begin
    strb.push   = tokReady && (act == ACT_SHIFT);
    strb.accept = tokReady && (act == ACT_ACCEPT);
    strb.reduce = run && (act == ACT_REDUCE);
    strb.kind   = kind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      if (doneSet) doneReg <= 1'b1;
      if (errSet)  errReg  <= 1'b1;
    end
  end

  assign parseDone  = doneReg;
  assign parseError = errReg;

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    parseError |=> parseError); // R3
  AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !(parseError && parseDone)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    parseDone |=> parseDone); // R7
  AST_LONG_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hit)); // R10

endmodule

// File: rtl/srExprEval.sv
module srExprEval
  import srExprPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ITEM_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tokValid,
  input  logic [ITEM_W-1:0]       tokIn,
  output logic                    tokReady,
  output logic                    parseDone,
  output logic                    parseError,
  output logic [ITEM_W-TAG_W-1:0] resultVal
);

  strobe_t           strb;
  logic [ITEM_W-1:0] top0, top1, top2;
  logic              full;

  srExprCtrl #(.ITEM_W(ITEM_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tokValid   (tokValid),
    .tokIn      (tokIn),
    .top0       (top0),
    .top1       (top1),
    .top2       (top2),
    .full       (full),
    .tokReady   (tokReady),
    .strb       (strb),
    .parseDone  (parseDone),
    .parseError (parseError)
  );

  srExprStack #(.DEPTH(DEPTH), .ITEM_W(ITEM_W)) i_stack (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .tokIn     (tokIn),
    .top0      (top0),
    .top1      (top1),
    .top2      (top2),
    .full      (full),
    .resultVal (resultVal)
  );

endmodule

// File: tb/test_srExprEval.sv
module test_srExprEval;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  localparam int T_BOT = 'h5A, T_END = 'h55, T_EXPR = 'hEE, T_TERM = 'hE7,
                 T_FACT = 'hEF, T_INT = 'hE1, T_OPEN = 'hCA, T_CLOSE = 'hCB,
                 T_ADD = 'hAA, T_MUL = 'hAB;
  localparam logic [15:0] K_OPEN = 16'hCA00, K_CLOSE = 16'hCB00,
                          K_ADD = 16'hAA00, K_MUL = 16'hAB00, K_END = 16'h5500;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tokValid = 1'b0;
  logic [15:0] tokIn = 16'h0;
  logic        tokReady, parseDone, parseError;
  logic [7:0]  resultVal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  srExprEval i_srExprEval (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokIn(tokIn),
    .tokReady(tokReady), .parseDone(parseDone), .parseError(parseError),
    .resultVal(resultVal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] num(input int v);
    return {8'hE1, 8'(v)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mTag[$];
  int mVal[$];
  bit mDone, mErr;
  int mRes;

  function automatic int tagAt(input int k);
    int n = mTag.size();
    return (n > k) ? mTag[n-1-k] : 0;
  endfunction

  function automatic int valAt(input int k);
    int n = mVal.size();
    return (n > k) ? mVal[n-1-k] : 0;
  endfunction

  task automatic mReduce(input int cnt, input int tag, input int val);
    repeat (cnt) begin
      void'(mTag.pop_back());
      void'(mVal.pop_back());
    end
    mTag.push_back(tag);
    mVal.push_back(val & 255);
  endtask

  task automatic mShift(output bit rdy);
    if (mTag.size() >= 16) begin
      mErr = 1; rdy = 0;
    end else begin
      mTag.push_back(int'(tokIn[15:8]));
      mVal.push_back(int'(tokIn[7:0]));
      rdy = 1;
    end
  endtask

  task automatic modelStep(output bit rdy);
    int look = int'(tokIn[15:8]);
    int t0 = tagAt(0), t1 = tagAt(1), t2 = tagAt(2);
    int v0 = valAt(0), v1 = valAt(1), v2 = valAt(2);
    bit isOp  = (look == T_INT) || (look == T_OPEN);
    bit isFol = (look == T_ADD) || (look == T_MUL) || (look == T_CLOSE) || (look == T_END);
    rdy = 0;
    if (t0 == T_BOT) begin
      if (isOp) mShift(rdy); else mErr = 1;
    end else if (t0 == T_EXPR && t1 == T_BOT) begin
      if (look == T_ADD) mShift(rdy);
      else if (look == T_END) begin rdy = 1; mDone = 1; mRes = v0; end
      else mErr = 1;
    end else if (t0 == T_EXPR && t1 == T_OPEN) begin
      if (look == T_ADD || look == T_CLOSE) mShift(rdy); else mErr = 1;
    end else if (t0 == T_TERM) begin
      if (look == T_MUL) mShift(rdy);
      else if (isFol) begin
        if (t1 == T_ADD && t2 == T_EXPR) mReduce(3, T_EXPR, v2 + v0);
        else mReduce(1, T_EXPR, v0);
      end else mErr = 1;
    end else if (t0 == T_FACT) begin
      if (!isFol) mErr = 1;
      else if (t1 == T_MUL && t2 == T_TERM) mReduce(3, T_TERM, v2 * v0);
      else mReduce(1, T_TERM, v0);
    end else if (t0 == T_INT) begin
      if (isFol) mReduce(1, T_FACT, v0); else mErr = 1;
    end else if (t0 == T_CLOSE && t1 == T_EXPR && t2 == T_OPEN) begin
      if (isFol) mReduce(3, T_FACT, v1); else mErr = 1;
    end else if (t0 == T_OPEN || (t0 == T_ADD && t1 == T_EXPR) || (t0 == T_MUL && t1 == T_TERM)) begin
      if (isOp) mShift(rdy); else mErr = 1;
    end else mErr = 1;
  endtask

  // Compare on every falling edge; model state then advances to the next rising edge.
  always @(negedge clk) begin
    bit expReady;
    if (!rstN) begin
      mTag = {}; mVal = {};
      mTag.push_back(T_BOT); mVal.push_back(0);
      mDone = 0; mErr = 0; mRes = 0;
    end else begin
      chk("R7", "model done", int'(parseDone), int'(mDone));
      chk("R3", "model error", int'(parseError), int'(mErr));
      chk("R7", "model result", int'(resultVal), mRes);
      expReady = 0;
      if (tokValid && !mDone && !mErr) modelStep(expReady);
      chk("R4", "model ready", int'(tokReady), int'(expReady));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL R4 watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReset();
    tokValid = 0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  // Offers one token until taken, or until the parser stops.
  task automatic sendTok(input logic [15:0] tok, output int waits);
    waits = 0;
    tokValid = 1;
    tokIn = tok;
    forever begin
      @(negedge clk);
      if (tokReady || parseError || parseDone || waits > 40) begin
        @(posedge clk); #1;
        tokValid = 0;
        break;
      end
      waits++;
      @(posedge clk); #1;
    end
  endtask

  task automatic runExpr(input logic [15:0] seq[$], input int expVal, input string req);
    int w;
    foreach (seq[i]) sendTok(seq[i], w);
    @(negedge clk);
    chk(req, "done", int'(parseDone), 1);
    chk(req, "error", int'(parseError), 0);
    chk(req, "result", int'(resultVal), expVal);
    @(posedge clk); #1;
    doReset();
  endtask

  initial begin
    int w;
    doReset();

    // R1: reset state, then an integer is taken at once
    @(negedge clk);
    chk("R1", "done after reset", int'(parseDone), 0);
    chk("R1", "error after reset", int'(parseError), 0);
    chk("R1", "result after reset", int'(resultVal), 0);
    @(posedge clk); #1;
    tokValid = 1; tokIn = num(5);
    @(negedge clk);
    chk("R1", "integer taken at start", int'(tokReady), 1);
    @(posedge clk); #1;
    tokValid = 0;
    sendTok(K_END, w);
    @(negedge clk);
    chk("R1", "single value result", int'(resultVal), 5);
    @(posedge clk); #1;
    doReset();

    // R9: nested parentheses
    runExpr('{K_OPEN, K_OPEN, num(2), K_CLOSE, K_ADD, num(3), K_CLOSE, K_ADD, num(1), K_END}, 6, "R9");

    // R5: precedence
    runExpr('{num(2), K_ADD, num(3), K_MUL, num(4), K_END}, 14, "R5");
    runExpr('{num(2), K_MUL, num(3), K_ADD, num(4), K_END}, 10, "R5");

    // R6: truncation of sum and product
    runExpr('{num(200), K_ADD, num(100), K_END}, 44, "R6");
    runExpr('{num(16), K_MUL, num(16), K_END}, 0, "R6");
    runExpr('{K_OPEN, num(7), K_MUL, num(3), K_CLOSE, K_MUL, num(2), K_END}, 42, "R6");

    // R2: value byte equal to the multiply tag is only data
    runExpr('{num(171), K_END}, 171, "R2");

    // R10: three-entry pattern decides over lone term
    runExpr('{num(1), K_ADD, num(2), K_END}, 3, "R10");

    // R4: the operator waits through three reductions
    sendTok(num(2), w);
    sendTok(K_ADD, w);
    chk("R4", "wait cycles before add", w, 3);
    sendTok(num(3), w);
    sendTok(K_END, w);
    chk("R4", "wait cycles before end", w, 3);
    @(negedge clk);
    chk("R4", "result after held tokens", int'(resultVal), 5);

    // R7: stopped after done
    @(posedge clk); #1;
    tokValid = 1; tokIn = num(9);
    @(negedge clk);
    chk("R7", "ready low after done", int'(tokReady), 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R7", "done held", int'(parseDone), 1);
    chk("R7", "result held", int'(resultVal), 5);
    @(posedge clk); #1;
    doReset();

    // R3: operator at start is illegal, parser stays stopped
    sendTok(K_ADD, w);
    @(negedge clk);
    chk("R3", "error on leading add", int'(parseError), 1);
    @(posedge clk); #1;
    tokValid = 1; tokIn = num(4);
    @(negedge clk);
    chk("R3", "ready low after error", int'(tokReady), 0);
    @(posedge clk); #1;
    tokValid = 0;
    doReset();

    // R3: end inside open parenthesis
    sendTok(K_OPEN, w);
    sendTok(num(2), w);
    sendTok(K_END, w);
    @(negedge clk);
    chk("R3", "error on end after open-expr", int'(parseError), 1);
    chk("R3", "no done on error", int'(parseDone), 0);
    @(posedge clk); #1;
    doReset();

    // R3: two integers in a row
    sendTok(num(2), w);
    sendTok(num(3), w);
    @(negedge clk);
    chk("R3", "error on int after int", int'(parseError), 1);
    @(posedge clk); #1;
    doReset();

    // R8: fifteen opens fill the stack, the sixteenth overflows
    for (int i = 0; i < 15; i++) sendTok(K_OPEN, w);
    @(negedge clk);
    chk("R8", "no error when full", int'(parseError), 0);
    @(posedge clk); #1;
    sendTok(K_OPEN, w);
    @(negedge clk);
    chk("R8", "error on push to full stack", int'(parseError), 1);
    @(posedge clk); #1;
    doReset();

    repeat (3) @(posedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule